// File: doc/BRIEF.md
# Floating-Point Exception Control and Status Register

This block holds the 32-bit control and status word that governs a floating-point datapath. The datapath reports, per operation, a six-bit vector of exception events together with a valid strobe. Each reported event sets a sticky flag that stays set until software rewrites the word. The block also drives a trap request toward the control logic whenever a reported exception has its mask bit clear. A masked exception never traps, and the datapath then delivers its default quiet NaN or infinity result. The block exports the rounding mode, flush-to-zero and denormals-are-zero controls to the datapath. The last two are performance modes that depart from IEEE 754 behaviour.

Software reaches the word through a plain register port. The write strobe and the write data are sampled on the clock edge. The read data always shows the current word. The event input is a valid-qualified stream with no ready signal, because the block never applies back-pressure. Every cycle in which the valid strobe is high is consumed in that same cycle. While valid is low the event bits are ignored.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the word reads 0x00001F80, which means every exception is masked, rounding is round-to-nearest (code 0), flush-to-zero and denormals-are-zero are off and all flags are clear. The trap and error outputs are low.
- R2: The word layout is as follows. Bits 0..5 are the sticky flags, in this order: invalid, denormal operand, divide-by-zero, overflow, underflow, inexact. Bit 6 is denormals-are-zero. Bits 7..12 are the masks for the same six exceptions in the same order. Bits 14:13 are the rounding mode and bit 15 is flush-to-zero. Bits 31..16 always read zero.
- R3: On a clock edge with ev_valid high, every set bit of ev_bits sets the matching flag, and the new flags are visible on rd_data after that edge. The block accepts an event on every cycle, with no back-pressure.
- R4: With ev_valid low, ev_bits has no effect on the flags, trap_req or trap_cause.
- R5: Flags stay set until software writes the word. An accepted write replaces the flags with wr_data[5:0].
- R6: When a write and an event arrive on the same edge, the flags become wr_data[5:0] OR ev_bits, so no event is lost.
- R7: A write whose bits 31..16 are nonzero leaves the word unchanged, apart from flags set by a same-cycle event. It pulses wr_err high for exactly one cycle after the edge.
- R8: One cycle after an edge with ev_valid high, trap_cause equals ev_bits AND NOT the mask bits that held before that edge. trap_req is high for that one cycle exactly when trap_cause is nonzero. Otherwise both are zero.
- R9: rnd_mode, ftz and daz always equal bits 14:13, bit 15 and bit 6 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current word |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| ev_valid | input | 1 | Event vector valid |
| ev_bits | input | 6 | Exception events, flag order |
| trap_req | output | 1 | Unmasked exception reported |
| trap_cause | output | 6 | Unmasked events that caused the trap |
| rnd_mode | output | 2 | Rounding mode to datapath |
| ftz | output | 1 | Flush-to-zero enable |
| daz | output | 1 | Denormals-are-zero enable |

## Verification
Directed sequences first drive single events against a fully masked word, which should set flags but never trap. They then unmask one exception and send multi-bit events, so the trap cause must isolate the unmasked bit from the masked ones. Further cases send event bits with valid low, a write on the same edge as an event, and a write with reserved bits set, which separates the merge, the ignore and the reject paths. A long run of mixed random writes and events then compares every output against a behavioural model on every clock. This run also catches mask changes that take effect one edge too early or too late.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W    = 32;
  localparam int USED_W   = 16;
  localparam int NEXC     = 6;
  localparam int DAZ_BIT  = 6;
  localparam int MASK_LO  = 7;
  localparam int RC_LO    = 13;
  localparam int RC_W     = 2;
  localparam int FTZ_BIT  = 15;
  localparam int CTRL_W   = USED_W - NEXC;
  localparam logic [CSR_W-1:0] CSR_RESET = 32'h0000_1F80;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  output logic              wr_ok,
  output logic              wr_err,
  output logic [CTRL_W-1:0] ctrl_bits,
  output logic [NEXC-1:0]   mask,
  output logic [RC_W-1:0]   rnd_mode,
  output logic              ftz,
  output logic              daz
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              resv_bad;

  assign resv_bad = |wr_data[CSR_W-1:USED_W];
  assign wr_ok    = wr_en && !resv_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CSR_RESET[USED_W-1:NEXC];
      wr_err <= 1'b0;
    end else begin
      if (wr_ok) ctrl_q <= wr_data[USED_W-1:NEXC];
      wr_err <= wr_en && resv_bad;
    end
  end

  assign ctrl_bits = ctrl_q;
  assign daz       = ctrl_q[DAZ_BIT-NEXC];
  assign mask      = ctrl_q[MASK_LO-NEXC +: NEXC];
  assign rnd_mode  = ctrl_q[RC_LO-NEXC +: RC_W];
  assign ftz       = ctrl_q[FTZ_BIT-NEXC];

  assert_resv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && resv_bad) |=> (ctrl_q == $past(ctrl_q) && wr_err));
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> !wr_err);
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(ctrl_q));
endmodule

// File: rtl/fpcsr_sticky.sv
module fpcsr_sticky
  import fpcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic [NEXC-1:0] wr_flags,
  input  logic            ev_valid,
  input  logic [NEXC-1:0] ev_bits,
  output logic [NEXC-1:0] flags
);
  logic [NEXC-1:0] flags_q;
  logic [NEXC-1:0] base;
  logic [NEXC-1:0] ev_q;

  assign ev_q = ev_valid ? ev_bits : '0;
  assign base = wr_ok ? wr_flags : flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= CSR_RESET[NEXC-1:0];
    else        flags_q <= base | ev_q;
  end

  assign flags = flags_q;

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  assert_event_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ((flags_q & $past(ev_bits)) == $past(ev_bits)));
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !wr_ok) |=> $stable(flags_q));
endmodule

// File: rtl/fpcsr_trap.sv
module fpcsr_trap
  import fpcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [NEXC-1:0] ev_bits,
  input  logic [NEXC-1:0] mask,
  output logic            trap_req,
  output logic [NEXC-1:0] trap_cause
);
  logic [NEXC-1:0] unmasked;

  for (genvar i = 0; i < NEXC; i++) begin : g_exc
    assign unmasked[i] = ev_valid && ev_bits[i] && !mask[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= |unmasked;
      trap_cause <= unmasked;
    end
  end

  assert_trap_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ((ev_bits & ~mask) == '0)) |=> !trap_req);
  assert_trap_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != '0));
  assert_trap_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid) |=> (!trap_req && trap_cause == '0));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  output logic [CSR_W-1:0]  rd_data,
  output logic              wr_err,
  input  logic              ev_valid,
  input  logic [NEXC-1:0]   ev_bits,
  output logic              trap_req,
  output logic [NEXC-1:0]   trap_cause,
  output logic [RC_W-1:0]   rnd_mode,
  output logic              ftz,
  output logic              daz
);
  logic              wr_ok;
  logic [CTRL_W-1:0] ctrl_bits;
  logic [NEXC-1:0]   mask;
  logic [NEXC-1:0]   flags;

  fpcsr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ok(wr_ok), .wr_err(wr_err), .ctrl_bits(ctrl_bits), .mask(mask),
    .rnd_mode(rnd_mode), .ftz(ftz), .daz(daz)
  );

  fpcsr_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_flags(wr_data[NEXC-1:0]),
    .ev_valid(ev_valid), .ev_bits(ev_bits), .flags(flags)
  );

  fpcsr_trap u_trap (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bits(ev_bits),
    .mask(mask), .trap_req(trap_req), .trap_cause(trap_cause)
  );

  assign rd_data = {{(CSR_W-USED_W){1'b0}}, ctrl_bits, flags};

  assert_write_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ev_valid) |=> (rd_data[NEXC-1:0] == ($past(wr_data[NEXC-1:0]) | $past(ev_bits))));
endmodule

// File: tb/tb_fpcsr_unit.sv
module tb_fpcsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wr_err;
  logic        ev_valid = 1'b0;
  logic [5:0]  ev_bits = '0;
  logic        trap_req;
  logic [5:0]  trap_cause;
  logic [1:0]  rnd_mode;
  logic        ftz, daz;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_word;
  logic        m_trap;
  logic [5:0]  m_cause;
  logic        m_err;

  always #2 clk = ~clk;

  fpcsr_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wr_err(wr_err), .ev_valid(ev_valid), .ev_bits(ev_bits), .trap_req(trap_req),
    .trap_cause(trap_cause), .rnd_mode(rnd_mode), .ftz(ftz), .daz(daz)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " word"}, {32'h0, rd_data}, {32'h0, m_word});
    chk({req, " trap"}, {57'h0, trap_req, trap_cause}, {57'h0, m_trap, m_cause});
    chk({req, " err"}, {63'h0, wr_err}, {63'h0, m_err});
    chk({req, " R9 ctrl"}, {60'h0, rnd_mode, ftz, daz},
        {60'h0, m_word[14:13], m_word[15], m_word[6]});
  endtask

  // one clock: drive at negedge, model the edge, compare shortly after it
  task automatic step(bit w, logic [31:0] wd, bit v, logic [5:0] eb, string req);
    bit reject;
    logic [15:0] nxt;
    @(negedge clk);
    wr_en = w; wr_data = wd; ev_valid = v; ev_bits = eb;
    @(posedge clk);
    reject  = w && (wd[31:16] != 16'h0);
    nxt     = (w && !reject) ? wd[15:0] : m_word[15:0];
    m_cause = v ? (eb & ~m_word[12:7]) : 6'h0;
    m_trap  = (m_cause != 6'h0);
    m_err   = reject;
    if (v) nxt[5:0] = nxt[5:0] | eb;
    m_word  = {16'h0, nxt};
    #1;
    compare_all(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_word = 32'h1F80; m_trap = 0; m_cause = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset value", {32'h0, rd_data}, 64'h1F80);
    compare_all("R1");

    // masked invalid event: flag bit 0 sets, no trap
    step(0, 0, 1, 6'b000001, "R3 masked invalid");
    chk("R3 invalid flag bit0", {32'h0, rd_data}, 64'h1F81);
    chk("R8 masked no trap", {63'h0, trap_req}, 64'h0);
    // bits offered without valid are ignored
    step(0, 0, 0, 6'b111110, "R4 no valid");
    chk("R4 flags unchanged", {32'h0, rd_data}, 64'h1F81);
    // flags survive idle cycles
    step(0, 0, 0, 0, "R5 hold");
    chk("R5 sticky", {32'h0, rd_data}, 64'h1F81);
    // unmask divide-by-zero (mask bit 9), clear flags
    step(1, 32'h0000_1D80, 0, 0, "R5 write");
    chk("R5 cleared by write", {32'h0, rd_data}, 64'h1D80);
    // divzero + overflow: only divzero traps
    step(0, 0, 1, 6'b001100, "R8 partial");
    chk("R8 cause divzero", {58'h0, trap_cause}, 64'h04);
    chk("R8 trap high", {63'h0, trap_req}, 64'h1);
    step(0, 0, 0, 0, "R8 pulse");
    chk("R8 one cycle", {63'h0, trap_req}, 64'h0);
    // write and event on the same edge merge
    step(1, 32'h0000_1D82, 1, 6'b100000, "R6 merge");
    chk("R6 merged flags", {32'h0, rd_data}, 64'h1DA2);
    // rejected write with reserved bits set, event still lands
    step(1, 32'h0001_E040, 1, 6'b010000, "R7 reject");
    chk("R7 word kept", {32'h0, rd_data}, 64'h1DB2);
    chk("R7 err pulse", {63'h0, wr_err}, 64'h1);
    step(0, 0, 0, 0, "R7 err clear");
    chk("R7 err one cycle", {63'h0, wr_err}, 64'h0);
    // control exports: ftz, rc=3, daz, all unmasked
    step(1, 32'h0000_E040, 0, 0, "R9 controls");
    chk("R9 rnd_mode", {62'h0, rnd_mode}, 64'h3);
    chk("R9 ftz daz", {62'h0, ftz, daz}, 64'h3);
    chk("R2 layout", {32'h0, rd_data}, 64'hE040);
    step(0, 0, 1, 6'b111111, "R8 all unmasked");
    chk("R8 all cause", {58'h0, trap_cause}, 64'h3F);
    // mask change and event on same edge: old mask decides
    step(1, 32'h0000_1F80, 1, 6'b000010, "R8 old mask");
    chk("R8 old mask traps", {63'h0, trap_req}, 64'h1);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] wd;
      bit w, v;
      w  = ($urandom_range(0, 3) == 0);
      v  = ($urandom_range(0, 1) == 1);
      wd = {($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'h0, 16'($urandom)};
      step(w, wd, v, 6'($urandom), "R3 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule